// File: doc/BRIEF.md
# Tagged Memory Burst Responder

This block sits at the memory end of a processor bus whose data flits carry hidden validity tags. A flit is one line of the store: by default 32 bytes of data plus one tag bit for each 16-byte capability chunk. The responder holds a small on-chip array of lines. Each line keeps its data bytes and its tag bits together.

The responder accepts read bursts and write bursts on a valid/ready request channel. It answers on a valid/ready response channel, and every response copies the master and transaction identifiers of the request it answers.

A read can be marked linked. A linked read arms a single reservation on its line. A later write can be marked conditional, and it stores only while that reservation still stands. Its response reports whether the store happened. Requests that address lines beyond the array get an error response with zero payload.

Top module: `tagmem_responder`

## Requirements
- R1: After reset `rsp_valid` is 0 and `req_ready` is 1, and every line of the array reads back as zero data with zero tags.
- R2: A read with `req_flits` = n returns n+1 flits, with `rsp_kind` = 0. The flits come from consecutive lines, starting at the line `req_addr[39:5]`; the low 5 address bits are ignored. `rsp_last` is 1 only on the final flit.
- R3: Every response carries the `req_mid` and `req_tid` values of the first flit of the request it answers.
- R4: A write flit changes only the bytes whose `req_be` bit is set. Byte i of the line is data bits [8i+7:8i].
- R5: On a write, tag bit c (covering bytes 16c to 16c+15) takes `req_tags[c]` only if all 16 of those enable bits are set. Otherwise the tag bit becomes 0.
- R6: A write burst stores flit k at line start+k. It produces exactly one response, after the flit with `req_last` = 1. That response has `rsp_kind` = 1 for a plain write or 2 for a conditional one, `rsp_last` = 1, and zero data and tags.
- R7: A conditional write (`req_cond` = 1) to the line of the live reservation stores its data and answers with `rsp_sc` = 1. `rsp_sc` is 0 in every other response.
- R8: A conditional write fails (`rsp_sc` = 0, memory unchanged) when no reservation stands or when it targets a different line. Any write that stores to the reserved line, from any master, cancels the reservation.
- R9: A conditional write cancels the reservation whether or not it succeeds, so a second conditional write fails.
- R10: A flit whose line is 16 or above (with the default 16 lines) gets `rsp_err` = 1 and zero data and tags. Read sequencing of `rsp_last` still holds. An out-of-range write flit stores nothing, and its burst response has `rsp_err` = 1.
- R11: While `rsp_valid` is 1 and `rsp_ready` is 0, every response output holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request flit valid |
| req_ready | output | 1 | Request flit accepted when high with valid |
| req_is_write | input | 1 | 1 = write flit, 0 = read request (first flit only) |
| req_addr | input | 40 | Byte address; upper 35 bits select the line |
| req_mid | input | 4 | Master identifier |
| req_tid | input | 4 | Transaction identifier |
| req_linked | input | 1 | Read arms the reservation |
| req_flits | input | 3 | Read flit count minus one |
| req_last | input | 1 | Final flit of a write burst |
| req_cond | input | 1 | Write is conditional (first flit) |
| req_be | input | 32 | Byte enables of a write flit |
| req_data | input | 256 | Write data |
| req_tags | input | 2 | Write tag bits, one per 16-byte chunk |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_mid | output | 4 | Echoed master identifier |
| rsp_tid | output | 4 | Echoed transaction identifier |
| rsp_kind | output | 2 | 0 read, 1 write, 2 conditional write |
| rsp_err | output | 1 | Address out of range |
| rsp_last | output | 1 | Final flit of the response |
| rsp_sc | output | 1 | Conditional store succeeded |
| rsp_data | output | 256 | Read data |
| rsp_tags | output | 2 | Read tag bits |

## Verification
A read accepted at one clock edge shows its first flit on `rsp_valid` after the next edge. Later flits follow one per cycle while `rsp_ready` stays high. A write response appears after the edge that accepts the flit marked last. Because that response is registered, the earliest a consumer can see it is the following cycle.

The bench drives inputs at the falling edge. A monitor checks each response 2 ns after a falling edge, in a cycle where both `rsp_valid` and `rsp_ready` are high, so that the values compared are the settled outputs of the preceding rising edge. Responses are compared in order against a queue that the driver filled from a reference model of lines, tags and the reservation. The stall test samples the held outputs several cycles apart before it releases `rsp_ready`.

// File: rtl/tagmem_pkg.sv
package tagmem_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WR   = 2'd1,
        ST_RD   = 2'd2
    } tm_state_e;

    typedef enum logic [1:0] {
        RK_READ  = 2'd0,
        RK_WRITE = 2'd1,
        RK_COND  = 2'd2
    } tm_rsp_kind_e;

endpackage

// File: rtl/tagmem_tagmerge.sv
module tagmem_tagmerge #(
    parameter int BUS_BYTES = 32,
    parameter int CAP_BYTES = 16,
    localparam int NTAG     = BUS_BYTES / CAP_BYTES
) (
    input  logic [BUS_BYTES-1:0] be_i,
    input  logic [NTAG-1:0]      tags_i,
    output logic [NTAG-1:0]      tags_o
);

    // a tag survives only when its whole chunk is rewritten
    for (genvar c = 0; c < NTAG; c++) begin : g_chunk
        assign tags_o[c] = (&be_i[c*CAP_BYTES +: CAP_BYTES]) & tags_i[c];
    end

endmodule

// File: rtl/tagmem_store.sv
module tagmem_store #(
    parameter int LINES     = 16,
    parameter int BUS_BYTES = 32,
    parameter int NTAG      = 2,
    localparam int IDX_W    = $clog2(LINES),
    localparam int DATA_W   = BUS_BYTES * 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we_i,
    input  logic [IDX_W-1:0]     widx_i,
    input  logic [BUS_BYTES-1:0] wbe_i,
    input  logic [DATA_W-1:0]    wdata_i,
    input  logic [NTAG-1:0]      wtags_i,
    input  logic [IDX_W-1:0]     ridx_i,
    output logic [DATA_W-1:0]    rdata_o,
    output logic [NTAG-1:0]      rtags_o
);

    logic [DATA_W-1:0] data_q [LINES];
    logic [NTAG-1:0]   tag_q  [LINES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int l = 0; l < LINES; l++) begin
                data_q[l] <= '0;
                tag_q[l]  <= '0;
            end
        end else if (we_i) begin
            for (int l = 0; l < LINES; l++) begin
                if (widx_i == IDX_W'(l)) begin
                    tag_q[l] <= wtags_i;
                    for (int b = 0; b < BUS_BYTES; b++) begin
                        if (wbe_i[b]) begin
                            data_q[l][b*8 +: 8] <= wdata_i[b*8 +: 8];
                        end
                    end
                end
            end
        end
    end

    assign rdata_o = data_q[ridx_i];
    assign rtags_o = tag_q[ridx_i];

endmodule

// File: rtl/tagmem_link.sv
module tagmem_link #(
    parameter int LINE_W = 35
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_i,
    input  logic [LINE_W-1:0] set_line_i,
    input  logic              kill_i,
    output logic              valid_o,
    output logic [LINE_W-1:0] line_o
);

    typedef struct packed {
        logic              armed;
        logic [LINE_W-1:0] line;
    } link_t;

    link_t link_d, link_q;

    always_comb begin
        link_d = link_q;
        if (kill_i) begin
            link_d.armed = 1'b0;
        end else if (set_i) begin
            link_d.armed = 1'b1;
            link_d.line  = set_line_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            link_q <= '0;
        end else begin
            link_q <= link_d;
        end
    end

    assign valid_o = link_q.armed;
    assign line_o  = link_q.line;

endmodule

// File: rtl/tagmem_responder.sv
module tagmem_responder
    import tagmem_pkg::*;
#(
    parameter int ADDR_W    = 40,
    parameter int BUS_BYTES = 32,
    parameter int CAP_BYTES = 16,
    parameter int LINES     = 16,
    parameter int ID_W      = 4,
    parameter int CNT_W     = 3,
    localparam int DATA_W   = BUS_BYTES * 8,
    localparam int NTAG     = BUS_BYTES / CAP_BYTES
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic                 req_is_write,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [ID_W-1:0]      req_mid,
    input  logic [ID_W-1:0]      req_tid,
    input  logic                 req_linked,
    input  logic [CNT_W-1:0]     req_flits,
    input  logic                 req_last,
    input  logic                 req_cond,
    input  logic [BUS_BYTES-1:0] req_be,
    input  logic [DATA_W-1:0]    req_data,
    input  logic [NTAG-1:0]      req_tags,
    output logic                 rsp_valid,
    input  logic                 rsp_ready,
    output logic [ID_W-1:0]      rsp_mid,
    output logic [ID_W-1:0]      rsp_tid,
    output logic [1:0]           rsp_kind,
    output logic                 rsp_err,
    output logic                 rsp_last,
    output logic                 rsp_sc,
    output logic [DATA_W-1:0]    rsp_data,
    output logic [NTAG-1:0]      rsp_tags
);

    localparam int OFF_W  = $clog2(BUS_BYTES);
    localparam int LINE_W = ADDR_W - OFF_W;
    localparam int IDX_W  = $clog2(LINES);

    typedef struct packed {
        tm_state_e         st;
        logic [ID_W-1:0]   mid;
        logic [ID_W-1:0]   tid;
        logic [LINE_W-1:0] line;
        logic [CNT_W-1:0]  remain;
        logic              cond;
        logic              ok;
        logic              err;
        logic              rv;
        logic [ID_W-1:0]   rmid;
        logic [ID_W-1:0]   rtid;
        tm_rsp_kind_e      rkind;
        logic              rerr;
        logic              rlast;
        logic              rsc;
        logic [DATA_W-1:0] rdata;
        logic [NTAG-1:0]   rtags;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              link_valid;
    logic [LINE_W-1:0] link_line;
    logic              link_set;
    logic              link_kill;
    logic              mem_we;
    logic [DATA_W-1:0] arr_rdata;
    logic [NTAG-1:0]   arr_rtags;
    logic [NTAG-1:0]   merged_tags;
    logic              slot_free;
    logic              idle;
    logic              accept;
    logic              wflit;
    logic [LINE_W-1:0] cur_line;
    logic              cur_in_rng;
    logic              rd_in_rng;
    logic              f_cond;
    logic              f_ok;
    logic              f_err;
    logic              unused_offset;

    assign unused_offset = ^req_addr[OFF_W-1:0];

    assign slot_free  = !ctl_q.rv || rsp_ready;
    assign idle       = (ctl_q.st == ST_IDLE);
    assign req_ready  = slot_free && (ctl_q.st != ST_RD);
    assign accept     = req_valid && req_ready;
    assign wflit      = accept && (!idle || req_is_write);
    assign cur_line   = idle ? req_addr[ADDR_W-1:OFF_W] : ctl_q.line;
    assign cur_in_rng = cur_line < LINE_W'(LINES);
    assign rd_in_rng  = ctl_q.line < LINE_W'(LINES);

    // conditional and error context is fixed by the first flit of a burst
    assign f_cond = idle ? req_cond : ctl_q.cond;
    assign f_ok   = idle ? (!req_cond || (link_valid && (link_line == cur_line)))
                         : ctl_q.ok;
    assign f_err  = (idle ? 1'b0 : ctl_q.err) | !cur_in_rng;

    assign mem_we    = wflit && cur_in_rng && f_ok;
    assign link_kill = (mem_we && link_valid && (link_line == cur_line))
                     || (wflit && idle && req_cond);
    assign link_set  = accept && idle && !req_is_write && req_linked && cur_in_rng;

    always_comb begin
        ctl_d = ctl_q;
        if (ctl_q.rv && rsp_ready) begin
            ctl_d.rv = 1'b0;
        end
        if (wflit) begin
            if (idle) begin
                ctl_d.mid = req_mid;
                ctl_d.tid = req_tid;
            end
            ctl_d.cond = f_cond;
            ctl_d.ok   = f_ok;
            ctl_d.err  = f_err;
            ctl_d.line = cur_line + LINE_W'(1);
            if (req_last) begin
                ctl_d.st    = ST_IDLE;
                ctl_d.rv    = 1'b1;
                ctl_d.rmid  = idle ? req_mid : ctl_q.mid;
                ctl_d.rtid  = idle ? req_tid : ctl_q.tid;
                ctl_d.rkind = f_cond ? RK_COND : RK_WRITE;
                ctl_d.rerr  = f_err;
                ctl_d.rlast = 1'b1;
                ctl_d.rsc   = f_cond && f_ok;
                ctl_d.rdata = '0;
                ctl_d.rtags = '0;
            end else begin
                ctl_d.st = ST_WR;
            end
        end else if (accept) begin
            ctl_d.st     = ST_RD;
            ctl_d.mid    = req_mid;
            ctl_d.tid    = req_tid;
            ctl_d.line   = cur_line;
            ctl_d.remain = req_flits;
        end else if ((ctl_q.st == ST_RD) && slot_free) begin
            ctl_d.rv     = 1'b1;
            ctl_d.rmid   = ctl_q.mid;
            ctl_d.rtid   = ctl_q.tid;
            ctl_d.rkind  = RK_READ;
            ctl_d.rerr   = !rd_in_rng;
            ctl_d.rlast  = (ctl_q.remain == '0);
            ctl_d.rsc    = 1'b0;
            ctl_d.rdata  = rd_in_rng ? arr_rdata : '0;
            ctl_d.rtags  = rd_in_rng ? arr_rtags : '0;
            ctl_d.line   = ctl_q.line + LINE_W'(1);
            ctl_d.remain = ctl_q.remain - CNT_W'(1);
            if (ctl_q.remain == '0) begin
                ctl_d.st = ST_IDLE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    tagmem_tagmerge #(
        .BUS_BYTES (BUS_BYTES),
        .CAP_BYTES (CAP_BYTES)
    ) i_tagmerge (
        .be_i   (req_be),
        .tags_i (req_tags),
        .tags_o (merged_tags)
    );

    tagmem_store #(
        .LINES     (LINES),
        .BUS_BYTES (BUS_BYTES),
        .NTAG      (NTAG)
    ) i_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (mem_we),
        .widx_i  (cur_line[IDX_W-1:0]),
        .wbe_i   (req_be),
        .wdata_i (req_data),
        .wtags_i (merged_tags),
        .ridx_i  (ctl_q.line[IDX_W-1:0]),
        .rdata_o (arr_rdata),
        .rtags_o (arr_rtags)
    );

    tagmem_link #(
        .LINE_W (LINE_W)
    ) i_link (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (link_set),
        .set_line_i (cur_line),
        .kill_i     (link_kill),
        .valid_o    (link_valid),
        .line_o     (link_line)
    );

    assign rsp_valid = ctl_q.rv;
    assign rsp_mid   = ctl_q.rmid;
    assign rsp_tid   = ctl_q.rtid;
    assign rsp_kind  = ctl_q.rkind;
    assign rsp_err   = ctl_q.rerr;
    assign rsp_last  = ctl_q.rlast;
    assign rsp_sc    = ctl_q.rsc;
    assign rsp_data  = ctl_q.rdata;
    assign rsp_tags  = ctl_q.rtags;

endmodule

// File: rtl/tagmem_responder_chk.sv
module tagmem_responder_chk #(
    parameter int BUS_BYTES = 32,
    parameter int CAP_BYTES = 16,
    parameter int ID_W      = 4,
    localparam int DATA_W   = BUS_BYTES * 8,
    localparam int NTAG     = BUS_BYTES / CAP_BYTES
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              rsp_ready,
    input logic [ID_W-1:0]   rsp_mid,
    input logic [ID_W-1:0]   rsp_tid,
    input logic [1:0]        rsp_kind,
    input logic              rsp_err,
    input logic              rsp_last,
    input logic              rsp_sc,
    input logic [DATA_W-1:0] rsp_data,
    input logic [NTAG-1:0]   rsp_tags
);

    // R11
    rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) && $stable(rsp_tags)
            && $stable(rsp_mid) && $stable(rsp_tid) && $stable(rsp_kind)
            && $stable(rsp_last) && $stable(rsp_err) && $stable(rsp_sc));

    // R10
    err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_err |-> (rsp_data == '0) && (rsp_tags == '0));

    // R6
    wr_rsp_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && (rsp_kind != 2'd0) |-> rsp_last && (rsp_data == '0) && (rsp_tags == '0));

    // R7
    sc_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_sc |-> (rsp_kind == 2'd2));

    // R2
    rd_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && (rsp_kind == 2'd0) && !rsp_last |-> !req_ready);

endmodule

bind tagmem_responder tagmem_responder_chk #(
    .BUS_BYTES (BUS_BYTES),
    .CAP_BYTES (CAP_BYTES),
    .ID_W      (ID_W)
) i_chk (.*);

// File: tb/test_tagmem_responder.sv
module test_tagmem_responder;

    localparam int CLK_PERIOD = 10;
    localparam int LINES      = 16;
    localparam int DW         = 256;
    localparam int NT         = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_is_write = 1'b0;
    logic [39:0]   req_addr = '0;
    logic [3:0]    req_mid = '0;
    logic [3:0]    req_tid = '0;
    logic          req_linked = 1'b0;
    logic [2:0]    req_flits = '0;
    logic          req_last = 1'b0;
    logic          req_cond = 1'b0;
    logic [31:0]   req_be = '0;
    logic [DW-1:0] req_data = '0;
    logic [NT-1:0] req_tags = '0;
    logic          rsp_valid;
    logic          rsp_ready = 1'b1;
    logic [3:0]    rsp_mid;
    logic [3:0]    rsp_tid;
    logic [1:0]    rsp_kind;
    logic          rsp_err;
    logic          rsp_last;
    logic          rsp_sc;
    logic [DW-1:0] rsp_data;
    logic [NT-1:0] rsp_tags;

    always #(CLK_PERIOD/2) clk = ~clk;

    tagmem_responder i_tagmem_responder (.*);

    typedef struct {
        logic [3:0]    mid;
        logic [3:0]    tid;
        logic [1:0]    kind;
        logic          err;
        logic          last;
        logic          sc;
        logic [DW-1:0] data;
        logic [NT-1:0] tags;
        string         rq;
    } exp_t;

    exp_t          sbq[$];
    logic [DW-1:0] m_data [LINES];
    logic [NT-1:0] m_tags [LINES];
    bit            lk_v;
    int            lk_line;
    int            n_tests = 0;
    int            n_fail  = 0;

    task automatic chk(string rq, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] mk(int s);
        logic [DW-1:0] r;
        for (int w = 0; w < 8; w++) r[w*32 +: 32] = 32'(s * 32'h0100_0193 + w * 7 + 1);
        return r;
    endfunction

    // monitor: compare every accepted response with the scoreboard head
    always @(negedge clk) begin
        #2;
        if (rst_n && rsp_valid && rsp_ready) begin
            if (sbq.size() == 0) begin
                chk("R3", "unexpected response", 1, 0);
            end else begin
                exp_t e;
                e = sbq.pop_front();
                chk(e.rq, "mid",  DW'(rsp_mid),  DW'(e.mid));
                chk(e.rq, "tid",  DW'(rsp_tid),  DW'(e.tid));
                chk(e.rq, "kind", DW'(rsp_kind), DW'(e.kind));
                chk(e.rq, "err",  DW'(rsp_err),  DW'(e.err));
                chk(e.rq, "last", DW'(rsp_last), DW'(e.last));
                chk(e.rq, "sc",   DW'(rsp_sc),   DW'(e.sc));
                chk(e.rq, "data", rsp_data,      e.data);
                chk(e.rq, "tags", DW'(rsp_tags), DW'(e.tags));
            end
        end
    end

    task automatic send_flit(bit w, int line, logic [3:0] mid, logic [3:0] tid, bit linked,
                             int flits, bit last, bit cond, logic [31:0] be,
                             logic [DW-1:0] data, logic [NT-1:0] tags);
        @(negedge clk);
        req_valid    = 1'b1;
        req_is_write = w;
        req_addr     = {35'(line), 5'h3};
        req_mid      = mid;
        req_tid      = tid;
        req_linked   = linked;
        req_flits    = 3'(flits);
        req_last     = last;
        req_cond     = cond;
        req_be       = be;
        req_data     = data;
        req_tags     = tags;
        #1;
        while (!req_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        #1;
        req_valid = 1'b0;
    endtask

    task automatic rd(logic [3:0] mid, logic [3:0] tid, int line, int cnt, bit linked, string rq);
        for (int i = 0; i <= cnt; i++) begin
            exp_t e;
            int l;
            l = line + i;
            e.mid = mid; e.tid = tid; e.kind = 2'd0; e.err = (l >= LINES);
            e.last = (i == cnt); e.sc = 1'b0; e.rq = rq;
            e.data = (l < LINES) ? m_data[l] : '0;
            e.tags = (l < LINES) ? m_tags[l] : '0;
            sbq.push_back(e);
        end
        if (linked && line < LINES) begin
            lk_v = 1'b1;
            lk_line = line;
        end
        send_flit(1'b0, line, mid, tid, linked, cnt, 1'b0, 1'b0, '0, '0, '0);
    endtask

    task automatic wr(logic [3:0] mid, logic [3:0] tid, int line, int n, bit cond,
                      logic [31:0] be, int seed, logic [NT-1:0] tags, string rq);
        bit ok;
        bit err;
        ok  = !cond || (lk_v && lk_line == line);
        err = 1'b0;
        if (cond) lk_v = 1'b0;
        for (int i = 0; i < n; i++) begin
            int l;
            logic [DW-1:0] d;
            l = line + i;
            d = mk(seed + i);
            if (l >= LINES) begin
                err = 1'b1;
            end else if (ok) begin
                for (int b = 0; b < 32; b++) if (be[b]) m_data[l][b*8 +: 8] = d[b*8 +: 8];
                for (int c = 0; c < NT; c++) m_tags[l][c] = (&be[c*16 +: 16]) & tags[c];
                if (lk_v && lk_line == l) lk_v = 1'b0;
            end
            if (i == n - 1) begin
                exp_t e;
                e.mid = mid; e.tid = tid; e.kind = cond ? 2'd2 : 2'd1; e.err = err;
                e.last = 1'b1; e.sc = cond && ok; e.data = '0; e.tags = '0; e.rq = rq;
                sbq.push_back(e);
            end
            send_flit(1'b1, l, mid, tid, 1'b0, 0, (i == n - 1), cond, be, d, tags);
        end
    endtask

    task automatic drain();
        while (sbq.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        logic [DW-1:0] held;
        for (int l = 0; l < LINES; l++) begin
            m_data[l] = '0;
            m_tags[l] = '0;
        end
        lk_v = 1'b0;
        lk_line = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk("R1", "rsp_valid after reset", DW'(rsp_valid), 0);
        chk("R1", "req_ready after reset", DW'(req_ready), 1);

        rd(4'h1, 4'h2, 3, 0, 1'b0, "R1");                       // R1 zero line
        wr(4'h5, 4'h9, 4, 3, 1'b0, '1, 100, 2'b11, "R6");       // R6 burst
        drain();
        rd(4'h2, 4'hA, 4, 2, 1'b0, "R2");                       // R2 R3 burst read
        drain();

        wr(4'h3, 4'h1, 10, 1, 1'b0, '1, 200, 2'b11, "R4");      // R4 full fill
        wr(4'h3, 4'h2, 10, 1, 1'b0, 32'h0001_FFFF, 300, 2'b11, "R5"); // R5 chunk1 partial
        wr(4'h3, 4'h3, 11, 1, 1'b0, '1, 400, 2'b11, "R5");
        wr(4'h3, 4'h4, 11, 1, 1'b0, 32'hFFFF_0000, 500, 2'b01, "R5");
        drain();
        rd(4'h4, 4'h5, 10, 1, 1'b0, "R4");
        drain();

        rd(4'h6, 4'h6, 6, 0, 1'b1, "R7");                       // R7 link + success
        wr(4'h6, 4'h7, 6, 1, 1'b1, '1, 600, 2'b10, "R7");
        wr(4'h6, 4'h8, 6, 1, 1'b1, '1, 700, 2'b11, "R9");       // R9 link consumed
        drain();
        rd(4'h6, 4'h9, 6, 0, 1'b0, "R9");

        rd(4'h1, 4'hB, 7, 0, 1'b1, "R8");                       // R8 other master write
        wr(4'h3, 4'hC, 7, 1, 1'b0, 32'h0000_00FF, 800, 2'b00, "R8");
        wr(4'h1, 4'hD, 7, 1, 1'b1, '1, 900, 2'b11, "R8");
        rd(4'h2, 4'h1, 8, 0, 1'b1, "R8");                       // R8 wrong line
        wr(4'h2, 4'h2, 9, 1, 1'b1, '1, 1000, 2'b11, "R8");
        drain();
        rd(4'h2, 4'h3, 7, 2, 1'b0, "R8");
        drain();

        rd(4'hE, 4'hF, 20, 1, 1'b0, "R10");                     // R10 out of range
        rd(4'hE, 4'h0, 15, 1, 1'b0, "R10");
        wr(4'hD, 4'h4, 18, 1, 1'b0, '1, 1100, 2'b11, "R10");
        wr(4'hD, 4'h5, 15, 2, 1'b0, '1, 1200, 2'b11, "R10");
        drain();
        rd(4'hD, 4'h6, 2, 0, 1'b0, "R10");
        drain();

        @(negedge clk);                                         // R11 stall
        rsp_ready = 1'b0;
        rd(4'h7, 4'h7, 4, 3, 1'b0, "R11");
        repeat (3) @(negedge clk);
        #1;
        chk("R11", "valid during stall", DW'(rsp_valid), 1);
        held = rsp_data;
        repeat (3) @(negedge clk);
        #1;
        chk("R11", "data held during stall", rsp_data, held);
        chk("R11", "still valid during stall", DW'(rsp_valid), 1);
        @(negedge clk);
        rsp_ready = 1'b1;
        drain();
        repeat (4) @(negedge clk);
        chk("R3", "scoreboard empty", DW'(sbq.size()), 0);
        finish_run();
    end

endmodule